// File: doc/BRIEF.md
# Dual-Context Master Priority Register File

This block keeps two complete sets of arbitration settings for one slave port of a multi-master interconnect. Each set has a priority register and a control register. The priority register packs one level field per master. The control register holds one high-priority-enable bit per master. A single-cycle register port writes and reads all four registers. A hardware context pin picks which set feeds the arbiter. Software can load an alternate configuration once, and hardware can then switch to it and back without reprogramming anything.

A priority write is checked before it is committed. If any two master fields in the write data carry the same level, the write is refused, the register keeps its old contents, and the response carries an error flag. Control-register writes and reads are never refused.

The register port has no back-pressure. Every cycle with `reg_en` high is an access. The block accepts it at once, and exactly one cycle later `reg_ack` answers it with `reg_err` and `reg_rdata`. The arbiter-facing outputs are not a stream. They are plain levels that always show the selected set. `NUM_MASTERS` must not exceed `2**LVL_W`, so that a set of unique levels exists.

Top module: `prio_ctx_regs`

## Requirements
- R1: After reset, both priority registers hold level m in field m (bits [m*LVL_W +: LVL_W]) for every master m, and both control registers hold zero.
- R2: A write (`reg_en`=1, `reg_we`=1) to a priority register is stored at the clock edge that samples it when all of its fields are distinct. Its response carries `reg_err`=0. Address 0 is the primary priority register and address 2 is the alternate priority register.
- R3: A priority write whose data has two or more equal fields leaves that register unchanged. Its response carries `reg_err`=1.
- R4: `reg_err` is high for exactly the one response cycle of a rejected priority write, and never without `reg_ack`.
- R5: A write to a control register stores the low NUM_MASTERS bits of `reg_wdata`, ignores the upper bits, and never signals an error. Address 1 is the primary control register and address 3 is the alternate control register.
- R6: With `ctx_sel`=0, `arb_prio` and `arb_hpe` show the primary set. With `ctx_sel`=1 they show the alternate set. They follow `ctx_sel` combinationally, without waiting for a clock.
- R7: A read (`reg_en`=1, `reg_we`=0) returns the addressed register on `reg_rdata` in its response cycle, with control registers zero-extended. It never signals an error and changes no register.
- R8: A write to one set leaves the other set unchanged.
- R9: `reg_ack` is high in the cycle after each cycle in which `reg_en` is high, and low in every other cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| ctx_sel | input | 1 | Context select: 0 primary set, 1 alternate set |
| reg_en | input | 1 | Register access strobe |
| reg_we | input | 1 | 1 write, 0 read |
| reg_addr | input | 2 | Register address (0..3) |
| reg_wdata | input | NUM_MASTERS*LVL_W | Write data |
| reg_ack | output | 1 | Response strobe, one cycle after the access |
| reg_err | output | 1 | Write refused (duplicate levels) |
| reg_rdata | output | NUM_MASTERS*LVL_W | Read data, zero on write responses |
| arb_prio | output | NUM_MASTERS*LVL_W | Selected per-master priority levels |
| arb_hpe | output | NUM_MASTERS | Selected per-master high-priority enables |

## Verification
A corrupted bank shows up on `arb_prio` or `arb_hpe` right away while its context is selected. It shows up in the response to any read of that bank one cycle after the read. A wrong duplicate decision shows up in the next response, either as a missing or spurious `reg_err` or as a register that changed when it should not have, and `arb_prio` makes the change visible in the same cycle. A fault in the context mux shows up between clock edges as soon as `ctx_sel` toggles, so the bench samples both contexts after every update.

// File: rtl/prio_ctx_pkg.sv
package prio_ctx_pkg;
  localparam int ADDR_W = 2;
  // bit 0 selects control vs. priority, bit 1 selects alternate vs. primary
  typedef enum logic [ADDR_W-1:0] {
    REG_PRI_A = 2'd0,
    REG_HPE_A = 2'd1,
    REG_PRI_B = 2'd2,
    REG_HPE_B = 2'd3
  } reg_sel_e;
endpackage

// File: rtl/prio_dup_detect.sv
module prio_dup_detect #(
  parameter int N = 8,
  parameter int W = 3
) (
  input  logic [N*W-1:0] fields,
  output logic           dup
);
  logic [N-1:0][N-1:0] hit;

  for (genvar i = 0; i < N; i++) begin : g_row
    for (genvar j = 0; j < N; j++) begin : g_col
      if (j > i) begin : g_cmp
        assign hit[i][j] = (fields[i*W +: W] == fields[j*W +: W]);
      end else begin : g_none
        assign hit[i][j] = 1'b0;
      end
    end
  end

  assign dup = |hit;
endmodule

// File: rtl/prio_reg_bank.sv
module prio_reg_bank #(
  parameter int N = 8,
  parameter int W = 3
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           pri_we,
  input  logic           ctl_we,
  input  logic [N*W-1:0] wdata,
  output logic [N*W-1:0] pri_q,
  output logic [N-1:0]   ctl_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int m = 0; m < N; m++) pri_q[m*W +: W] <= W'(m);
    end else if (pri_we) begin
      pri_q <= wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      ctl_q <= '0;
    else if (ctl_we) ctl_q <= wdata[N-1:0];
  end
endmodule

// File: rtl/prio_ctx_mux.sv
module prio_ctx_mux #(
  parameter int N = 8,
  parameter int W = 3
) (
  input  logic           sel,
  input  logic [N*W-1:0] pri_a,
  input  logic [N-1:0]   ctl_a,
  input  logic [N*W-1:0] pri_b,
  input  logic [N-1:0]   ctl_b,
  output logic [N*W-1:0] pri_o,
  output logic [N-1:0]   ctl_o
);
  always_comb begin
    pri_o = sel ? pri_b : pri_a;
    ctl_o = sel ? ctl_b : ctl_a;
  end
endmodule

// File: rtl/prio_ctx_regs.sv
module prio_ctx_regs
  import prio_ctx_pkg::*;
#(
  parameter int NUM_MASTERS = 8,
  parameter int LVL_W       = 3
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         ctx_sel,
  input  logic                         reg_en,
  input  logic                         reg_we,
  input  logic [1:0]                   reg_addr,
  input  logic [NUM_MASTERS*LVL_W-1:0] reg_wdata,
  output logic                         reg_ack,
  output logic                         reg_err,
  output logic [NUM_MASTERS*LVL_W-1:0] reg_rdata,
  output logic [NUM_MASTERS*LVL_W-1:0] arb_prio,
  output logic [NUM_MASTERS-1:0]       arb_hpe
);
  localparam int PW     = NUM_MASTERS * LVL_W;
  localparam int NBANKS = 2;

  reg_sel_e                       sel;
  logic                           wr;
  logic                           dup;
  logic [NBANKS-1:0][PW-1:0]      pri_q;
  logic [NBANKS-1:0][NUM_MASTERS-1:0] ctl_q;
  logic [PW-1:0]                  rd_next;

  assign sel = reg_sel_e'(reg_addr);
  assign wr  = reg_en && reg_we;

  prio_dup_detect #(.N(NUM_MASTERS), .W(LVL_W)) u_dup (
    .fields (reg_wdata),
    .dup    (dup)
  );

  for (genvar b = 0; b < NBANKS; b++) begin : g_bank
    logic pri_we_b, ctl_we_b;
    assign pri_we_b = wr && (sel == ((b == 0) ? REG_PRI_A : REG_PRI_B)) && !dup;
    assign ctl_we_b = wr && (sel == ((b == 0) ? REG_HPE_A : REG_HPE_B));

    prio_reg_bank #(.N(NUM_MASTERS), .W(LVL_W)) u_bank (
      .clk    (clk),
      .rst_n  (rst_n),
      .pri_we (pri_we_b),
      .ctl_we (ctl_we_b),
      .wdata  (reg_wdata),
      .pri_q  (pri_q[b]),
      .ctl_q  (ctl_q[b])
    );
  end

  prio_ctx_mux #(.N(NUM_MASTERS), .W(LVL_W)) u_mux (
    .sel   (ctx_sel),
    .pri_a (pri_q[0]),
    .ctl_a (ctl_q[0]),
    .pri_b (pri_q[1]),
    .ctl_b (ctl_q[1]),
    .pri_o (arb_prio),
    .ctl_o (arb_hpe)
  );

  always_comb begin
    if (reg_addr[0]) rd_next = PW'(ctl_q[reg_addr[1]]);
    else             rd_next = pri_q[reg_addr[1]];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      reg_ack   <= 1'b0;
      reg_err   <= 1'b0;
      reg_rdata <= '0;
    end else begin
      reg_ack   <= reg_en;
      reg_err   <= wr && !reg_addr[0] && dup;
      reg_rdata <= (reg_en && !reg_we) ? rd_next : '0;
    end
  end
endmodule

// File: rtl/prio_ctx_regs_chk.sv
module prio_ctx_regs_chk #(
  parameter int NUM_MASTERS = 8,
  parameter int LVL_W       = 3
) (
  input logic                         clk,
  input logic                         rst_n,
  input logic                         ctx_sel,
  input logic                         reg_en,
  input logic                         reg_we,
  input logic [1:0]                   reg_addr,
  input logic                         reg_ack,
  input logic                         reg_err,
  input logic [NUM_MASTERS*LVL_W-1:0] arb_prio,
  input logic [NUM_MASTERS-1:0]       arb_hpe
);
  localparam int PW = NUM_MASTERS * LVL_W;

  logic past_ok;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) past_ok <= 1'b0;
    else        past_ok <= 1'b1;
  end

  function automatic logic all_distinct(input logic [PW-1:0] v);
    for (int i = 0; i < NUM_MASTERS; i++)
      for (int j = i + 1; j < NUM_MASTERS; j++)
        if (v[i*LVL_W +: LVL_W] == v[j*LVL_W +: LVL_W]) return 1'b0;
    return 1'b1;
  endfunction

  // R9: one response per access, one cycle later
  a_r9_ack_follows_access: assert property (@(posedge clk) disable iff (!rst_n)
    past_ok |-> (reg_ack == $past(reg_en)));

  // R4: error only inside a response
  a_r4_err_with_ack: assert property (@(posedge clk) disable iff (!rst_n)
    reg_err |-> reg_ack);

  // R4/R5/R7: error only answers a priority-register write
  a_r4_err_only_prio_write: assert property (@(posedge clk) disable iff (!rst_n)
    (past_ok && reg_err) |-> $past(reg_en && reg_we && !reg_addr[0]));

  // R3: refused write leaves visible levels as they were
  a_r3_reject_keeps_levels: assert property (@(posedge clk) disable iff (!rst_n)
    (past_ok && reg_err && (ctx_sel == $past(ctx_sel))) |-> $stable(arb_prio));

  // R2/R3: the selected levels are always a set of distinct values
  a_r2_levels_distinct: assert property (@(posedge clk) disable iff (!rst_n)
    all_distinct(arb_prio));

  // R7: without a write and with a steady select, outputs hold
  a_r7_idle_outputs_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (past_ok && !$past(reg_en && reg_we) && (ctx_sel == $past(ctx_sel)))
      |-> ($stable(arb_prio) && $stable(arb_hpe)));
endmodule

bind prio_ctx_regs prio_ctx_regs_chk #(.NUM_MASTERS(NUM_MASTERS), .LVL_W(LVL_W)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .ctx_sel  (ctx_sel),
  .reg_en   (reg_en),
  .reg_we   (reg_we),
  .reg_addr (reg_addr),
  .reg_ack  (reg_ack),
  .reg_err  (reg_err),
  .arb_prio (arb_prio),
  .arb_hpe  (arb_hpe)
);

// File: tb/sim_prio_ctx_regs.sv
module sim_prio_ctx_regs;
  localparam int CLK_PERIOD = 10;
  localparam int NM = 8;
  localparam int LW = 3;
  localparam int PW = NM * LW;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          ctx_sel = 1'b0;
  logic          reg_en = 1'b0;
  logic          reg_we = 1'b0;
  logic [1:0]    reg_addr = '0;
  logic [PW-1:0] reg_wdata = '0;
  logic          reg_ack, reg_err;
  logic [PW-1:0] reg_rdata, arb_prio;
  logic [NM-1:0] arb_hpe;

  int n_chk = 0;
  int n_err = 0;
  bit done  = 1'b0;

  logic [PW-1:0] exp_pri [2];
  logic [NM-1:0] exp_ctl [2];

  prio_ctx_regs #(.NUM_MASTERS(NM), .LVL_W(LW)) u0 (
    .clk(clk), .rst_n(rst_n), .ctx_sel(ctx_sel), .reg_en(reg_en), .reg_we(reg_we),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_ack(reg_ack), .reg_err(reg_err),
    .reg_rdata(reg_rdata), .arb_prio(arb_prio), .arb_hpe(arb_hpe)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [PW-1:0] rot_levels(input int k);
    logic [PW-1:0] v;
    for (int m = 0; m < NM; m++) v[m*LW +: LW] = LW'((m + k) % NM);
    return v;
  endfunction

  function automatic logic [PW-1:0] rev_levels();
    logic [PW-1:0] v;
    for (int m = 0; m < NM; m++) v[m*LW +: LW] = LW'(NM - 1 - m);
    return v;
  endfunction

  task automatic check(input string req, input logic [PW-1:0] act, input logic [PW-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
    end
  endtask

  // one access, sampled in its response cycle at the falling edge
  task automatic access(input logic we, input logic [1:0] a, input logic [PW-1:0] d,
                        output logic ack, output logic err, output logic [PW-1:0] rd);
    @(negedge clk);
    reg_en = 1'b1; reg_we = we; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_en = 1'b0; reg_we = 1'b0;
    ack = reg_ack; err = reg_err; rd = reg_rdata;
  endtask

  task automatic check_both_ctx(input string req);
    ctx_sel = 1'b0; #1;
    check(req, arb_prio, exp_pri[0]);
    check(req, PW'(arb_hpe), PW'(exp_ctl[0]));
    ctx_sel = 1'b1; #1;
    check(req, arb_prio, exp_pri[1]);
    check(req, PW'(arb_hpe), PW'(exp_ctl[1]));
    ctx_sel = 1'b0; #1;
  endtask

  task automatic t_reset();
    logic a, e; logic [PW-1:0] rd;
    check_both_ctx("R1 reset state");
    for (int r = 0; r < 4; r++) begin
      access(1'b0, 2'(r), '0, a, e, rd);
      check("R7 read ack", PW'(a), PW'(1));
      check("R7 read no error", PW'(e), '0);
      check("R1 reset readback", rd, r[0] ? PW'(exp_ctl[r/2]) : exp_pri[r/2]);
    end
  endtask

  task automatic t_write_unique();
    logic a, e; logic [PW-1:0] rd;
    access(1'b1, 2'd0, rot_levels(3), a, e, rd);
    check("R2 ack", PW'(a), PW'(1));
    check("R2 no error", PW'(e), '0);
    exp_pri[0] = rot_levels(3);
    check_both_ctx("R2/R8 primary written, alternate kept");
    access(1'b1, 2'd2, rev_levels(), a, e, rd);
    check("R2 alt no error", PW'(e), '0);
    exp_pri[1] = rev_levels();
    check_both_ctx("R2/R8 alternate written, primary kept");
  endtask

  task automatic t_write_dup();
    logic a, e; logic [PW-1:0] rd; logic [PW-1:0] bad;
    bad = rot_levels(1);
    bad[5*LW +: LW] = bad[0*LW +: LW];
    access(1'b1, 2'd2, bad, a, e, rd);
    check("R3 ack", PW'(a), PW'(1));
    check("R3 error flagged", PW'(e), PW'(1));
    check_both_ctx("R3 register unchanged");
    @(negedge clk);
    check("R4 error lasts one cycle", PW'(reg_err), '0);
    check("R9 no ack when idle", PW'(reg_ack), '0);
    access(1'b1, 2'd0, '0, a, e, rd);
    check("R3 all-equal write flagged", PW'(e), PW'(1));
    check_both_ctx("R3 all-equal write discarded");
  endtask

  task automatic t_ctrl();
    logic a, e; logic [PW-1:0] rd;
    access(1'b1, 2'd1, 24'hFFFF5A, a, e, rd);
    check("R5 ctrl write no error", PW'(e), '0);
    exp_ctl[0] = 8'h5A;
    access(1'b1, 2'd3, 24'h0012A5, a, e, rd);
    check("R5 alt ctrl no error", PW'(e), '0);
    exp_ctl[1] = 8'hA5;
    check_both_ctx("R5/R8 ctrl values");
    access(1'b0, 2'd1, '0, a, e, rd);
    check("R5 upper bits ignored on readback", rd, PW'(8'h5A));
    access(1'b0, 2'd3, '0, a, e, rd);
    check("R5 alt ctrl readback", rd, PW'(8'hA5));
  endtask

  task automatic t_ctx_switch();
    @(negedge clk);
    #2 ctx_sel = 1'b1; #1;
    check("R6 switch to alternate mid-cycle", arb_prio, exp_pri[1]);
    check("R6 hpe alternate mid-cycle", PW'(arb_hpe), PW'(exp_ctl[1]));
    ctx_sel = 1'b0; #1;
    check("R6 switch back to primary", arb_prio, exp_pri[0]);
  endtask

  task automatic t_read_back_to_back();
    @(negedge clk);
    reg_en = 1'b1; reg_we = 1'b0; reg_addr = 2'd0;
    @(negedge clk);
    check("R9 ack first read", PW'(reg_ack), PW'(1));
    check("R7 read primary priority", reg_rdata, exp_pri[0]);
    reg_addr = 2'd2;
    @(negedge clk);
    reg_en = 1'b0;
    check("R9 ack second read", PW'(reg_ack), PW'(1));
    check("R7 read alternate priority", reg_rdata, exp_pri[1]);
    check("R7 read no error", PW'(reg_err), '0);
    @(negedge clk);
    check("R9 ack drops", PW'(reg_ack), '0);
    check_both_ctx("R7 reads change nothing");
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_err++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    exp_pri[0] = rot_levels(0); exp_pri[1] = rot_levels(0);
    exp_ctl[0] = '0; exp_ctl[1] = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R9 no ack after reset", PW'(reg_ack), '0);
    t_reset();
    t_write_unique();
    t_write_dup();
    t_ctrl();
    t_ctx_switch();
    t_read_back_to_back();
    repeat (2) @(negedge clk);
    finish_run();
  end
endmodule